// File: doc/BRIEF.md
# USB Device Suspend and Status Monitor

This block sits beside a full-speed USB device port and keeps a packed, read-only status word up to date every cycle. It synchronises the sampled D+ and D- levels and treats any change of the pair as bus activity. A long enough stretch with no activity puts the port into the suspended state. Suspend ends when the lines move again or when software asks for remote wakeup. The block also latches the frame number carried by each start-of-frame strobe.

An erratic-error pulse forces the port into suspend and sets a sticky error flag. This condition is cleared only by a soft-disconnect request: line activity and remote wakeup have no effect on it. Each entry into suspend, whatever its cause, produces a one-cycle early-suspend interrupt pulse. The status word is a register: its fields follow the internal state one cycle later.

Top module: `usb_susp_mon`

## Requirements
- R1: While rst_ni is low, status_o reads 32'h0000_0010.
- R2: From the second clock edge after reset release, status_o bits 2:1 read 2'b11 (full speed), and bits 31:24 and 7:4 read zero.
- R3: status_o bit 23 shows dp_i and bit 22 shows dm_i, each after a two-flop synchroniser, no more than 4 cycles after the input changes.
- R4: status_o bits 21:8 load sof_frame_i on every cycle where sof_i is high, and keep their value while sof_i is low.
- R5: status_o bit 0 (suspend) sets after IDLE_CYCLES consecutive cycles with no change on the synchronised line pair. Any change restarts the count, and after a resume a new suspend needs another full idle period.
- R6: A suspend caused by idle is cleared by a change on the line pair.
- R7: A suspend caused by idle is cleared by a one-cycle pulse on rwake_i.
- R8: esusp_irq_o is a single-cycle pulse on each entry into suspend, whether the cause is idle timeout or an erratic error. It does not pulse when the port is already suspended.
- R9: A pulse on erratic_i sets status_o bit 3 (erratic error), which stays set, and forces bit 0.
- R10: While bit 3 is set, line activity and rwake_i leave bits 3 and 0 unchanged. A pulse on soft_disc_i clears both bits. When erratic_i and soft_disc_i are high in the same cycle, erratic_i wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | PHY-side clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dp_i | input | 1 | Sampled D+ level, asynchronous |
| dm_i | input | 1 | Sampled D- level, asynchronous |
| sof_i | input | 1 | Start-of-frame received strobe |
| sof_frame_i | input | 14 | Frame number carried by the start-of-frame |
| erratic_i | input | 1 | Erratic-error event pulse |
| rwake_i | input | 1 | Software remote-wakeup write pulse |
| soft_disc_i | input | 1 | Soft-disconnect request pulse |
| status_o | output | 32 | Packed status word |
| esusp_irq_o | output | 1 | Early-suspend interrupt pulse |

## Verification
A wrong suspend or error state appears directly at bit 0 or bit 3 of status_o one cycle after the internal flag changes. If the idle counter is wrong, suspend appears too early or too late compared with a window of plus or minus eight cycles around IDLE_CYCLES measured from the last line change. If the sticky flag is lost, or a resume path is missing, the bench sees it within three cycles of the stimulus that should or should not clear it. It also counts interrupt pulses, so a missing, repeated or extra early-suspend pulse is found at the next count comparison.

// File: rtl/usb_susp_pkg.sv
package usb_susp_pkg;
  localparam int STAT_W  = 32;
  localparam int FRAME_W = 14;
  localparam logic [1:0] SPD_FULL = 2'b11;
  localparam logic [STAT_W-1:0] STAT_RST = 32'h0000_0010;

  typedef struct packed {
    logic               dp;
    logic               dm;
    logic [FRAME_W-1:0] frame;
    logic               err;
    logic               susp;
  } stat_fields_t;

  function automatic logic [STAT_W-1:0] pack_status(stat_fields_t f);
    logic [STAT_W-1:0] w;
    w        = '0;
    w[23]    = f.dp;
    w[22]    = f.dm;
    w[21:8]  = f.frame;
    w[3]     = f.err;
    w[2:1]   = SPD_FULL;
    w[0]     = f.susp;
    return w;
  endfunction
endpackage

// File: rtl/usb_line_sync.sv
module usb_line_sync #(
  parameter int STAGES = 2,
  parameter int W      = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic         chg_o
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [W-1:0]             prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q  <= '0;
      prev_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      prev_q <= stg_q[STAGES-1];
    end
  end

  assign q_o   = stg_q[STAGES-1];
  assign chg_o = (stg_q[STAGES-1] != prev_q);
endmodule

// File: rtl/usb_idle_timer.sv
module usb_idle_timer #(
  parameter int IDLE_CYCLES = 144000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic chg_i,
  input  logic hold_i,
  output logic tmo_o
);
  localparam int CW = $clog2(IDLE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(IDLE_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign tmo_o = !hold_i && !chg_i && (cnt_q == LAST);

  // cleared while suspended so a resume needs a full fresh period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (hold_i || chg_i || tmo_o)  cnt_q <= '0;
    else                                cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/usb_susp_ctrl.sv
module usb_susp_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tmo_i,
  input  logic chg_i,
  input  logic rwake_i,
  input  logic erratic_i,
  input  logic soft_disc_i,
  output logic susp_o,
  output logic err_o,
  output logic irq_o
);
  logic susp_q, err_q, irq_q;
  logic enter;

  assign enter = !susp_q && (erratic_i || (tmo_i && !soft_disc_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      susp_q <= 1'b0;
      err_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= enter;
      if (erratic_i) begin
        err_q  <= 1'b1;
        susp_q <= 1'b1;
      end else if (soft_disc_i) begin
        err_q  <= 1'b0;
        susp_q <= 1'b0;
      end else if (err_q) begin
        susp_q <= 1'b1;
      end else if (susp_q && (chg_i || rwake_i)) begin
        susp_q <= 1'b0;
      end else if (!susp_q && tmo_i) begin
        susp_q <= 1'b1;
      end
    end
  end

  assign susp_o = susp_q;
  assign err_o  = err_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/usb_susp_mon.sv
module usb_susp_mon
  import usb_susp_pkg::*;
#(
  parameter int IDLE_CYCLES = 144000,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               dp_i,
  input  logic               dm_i,
  input  logic               sof_i,
  input  logic [FRAME_W-1:0] sof_frame_i,
  input  logic               erratic_i,
  input  logic               rwake_i,
  input  logic               soft_disc_i,
  output logic [STAT_W-1:0]  status_o,
  output logic               esusp_irq_o
);
  logic [1:0]         line_s;
  logic               line_chg;
  logic               tmo;
  logic               susp_q, err_q;
  logic [FRAME_W-1:0] frame_q;
  logic [STAT_W-1:0]  status_q;
  stat_fields_t       fld;

  usb_line_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({dp_i, dm_i}),
    .q_o   (line_s),
    .chg_o (line_chg)
  );

  usb_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .chg_i (line_chg),
    .hold_i(susp_q),
    .tmo_o (tmo)
  );

  usb_susp_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tmo_i      (tmo),
    .chg_i      (line_chg),
    .rwake_i    (rwake_i),
    .erratic_i  (erratic_i),
    .soft_disc_i(soft_disc_i),
    .susp_o     (susp_q),
    .err_o      (err_q),
    .irq_o      (esusp_irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    frame_q <= '0;
    else if (sof_i) frame_q <= sof_frame_i;
  end

  always_comb begin
    fld.dp    = line_s[1];
    fld.dm    = line_s[0];
    fld.frame = frame_q;
    fld.err   = err_q;
    fld.susp  = susp_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= STAT_RST;
    else         status_q <= pack_status(fld);
  end

  assign status_o = status_q;
endmodule

// File: rtl/usb_susp_mon_chk.sv
module usb_susp_mon_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] status_o,
  input logic        esusp_irq_o,
  input logic        soft_disc_i,
  input logic        sof_i,
  input logic        susp_q,
  input logic        err_q,
  input logic [13:0] frame_q
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  AST_SPEED_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> status_o[2:1] == 2'b11); // R2
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> (status_o[31:24] == 8'h00 && status_o[7:4] == 4'h0)); // R2
  AST_FRAME_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !$past(sof_i)) |-> $stable(frame_q)); // R4
  AST_IRQ_ON_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(susp_q) |-> esusp_irq_o); // R8
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    esusp_irq_o |=> !esusp_irq_o); // R8
  AST_ERR_FORCES_SUSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> susp_q); // R9
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !soft_disc_i) |=> err_q); // R10
endmodule

bind usb_susp_mon usb_susp_mon_chk u_chk (.*);

// File: tb/usb_susp_mon_test.sv
module usb_susp_mon_test;
  localparam int IDLE = 64;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        dp_i = 1'b0, dm_i = 1'b0;
  logic        sof_i = 1'b0;
  logic [13:0] sof_frame_i = '0;
  logic        erratic_i = 1'b0, rwake_i = 1'b0, soft_disc_i = 1'b0;
  logic [31:0] status_o;
  logic        esusp_irq_o;

  int errors = 0, checks = 0, irq_cnt = 0;
  logic m_dp = 0, m_dm = 0, m_er = 0, m_su = 0;
  logic [13:0] m_fr = '0;

  usb_susp_mon #(.IDLE_CYCLES(IDLE), .SYNC_STAGES(2)) uut (.*);

  always #4 clk_i = ~clk_i;

  always @(negedge clk_i) if (rst_ni && esusp_irq_o) irq_cnt++;

  function automatic logic [31:0] exp_word(logic dp, logic dm, logic [13:0] fr,
                                           logic er, logic su);
    return (32'(dp) << 23) | (32'(dm) << 22) | (32'(fr) << 8) |
           (32'(er) << 3) | (32'd3 << 1) | 32'(su);
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic chk_word(string req, logic [31:0] exp);
    checks++;
    if (status_o !== exp) begin
      errors++;
      $display("FAIL %s: status=%h expected=%h", req, status_o, exp);
    end
  endtask

  task automatic chk_model(string req);
    chk_word(req, exp_word(m_dp, m_dm, m_fr, m_er, m_su));
  endtask

  task automatic chk_irq(string req, int exp);
    checks++;
    if (irq_cnt != exp) begin
      errors++;
      $display("FAIL %s: irq_count=%0d expected=%0d", req, irq_cnt, exp);
    end
  endtask

  task automatic toggle_lines();
    logic [1:0] nv;
    nv = {m_dp, m_dm} ^ 2'($urandom_range(1, 3));
    m_dp = nv[1]; m_dm = nv[0];
    dp_i = m_dp;  dm_i = m_dm;
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1; tick(1); sig = 1'b0;
  endtask

  task automatic send_sof(logic [13:0] fr);
    sof_frame_i = fr; sof_i = 1'b1; tick(1);
    sof_i = 1'b0; sof_frame_i = 14'($urandom);
    m_fr = fr;
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog: cycles=50000 expected=finish");
    summary();
  end

  initial begin
    int base;
    void'($urandom(32'd2024));
    tick(3);
    chk_word("R1 reset word", 32'h0000_0010);
    rst_ni = 1'b1;
    tick(3);
    chk_model("R2 post-reset fields");

    // line levels and frame capture, with a line change each step
    for (int i = 0; i < 6; i++) begin
      toggle_lines();
      send_sof(14'($urandom));
      tick(4);
      chk_model("R3 R4 lines and frame");
    end
    sof_frame_i = ~m_fr; tick(4);
    chk_model("R4 frame held without strobe");

    // idle timeout
    base = irq_cnt;
    toggle_lines();
    tick(IDLE - 8);
    chk_model("R5 no suspend before idle period");
    tick(16);
    m_su = 1'b1;
    chk_model("R5 suspend after idle period");
    chk_irq("R8 one pulse on idle entry", base + 1);
    rwake_i = 1'b0;

    // activity resumes, new full period needed
    toggle_lines(); tick(5);
    m_su = 1'b0;
    chk_model("R6 line activity ends suspend");
    tick(IDLE - 12);
    chk_model("R5 idle count restarted after resume");
    tick(20);
    m_su = 1'b1;
    chk_model("R5 suspend again after full period");
    chk_irq("R8 pulse on second entry", base + 2);
    pulse(rwake_i); tick(3);
    m_su = 1'b0;
    chk_model("R7 remote wakeup ends suspend");

    // random activity keeps port awake
    base = irq_cnt;
    for (int i = 0; i < 40; i++) begin
      int gap;
      toggle_lines();
      if ($urandom_range(0, 1) == 1) send_sof(14'($urandom));
      if ($urandom_range(0, 3) == 0) pulse(rwake_i);
      gap = $urandom_range(5, IDLE / 2);
      tick(gap);
      chk_model("R5 R3 R4 random activity");
    end
    chk_irq("R8 no pulse while active", base);

    // erratic error
    base = irq_cnt;
    pulse(erratic_i); tick(3);
    m_er = 1'b1; m_su = 1'b1;
    chk_model("R9 erratic sets error and suspend");
    chk_irq("R8 pulse on erratic entry", base + 1);
    toggle_lines(); tick(5);
    chk_model("R10 activity ignored under error");
    pulse(rwake_i); tick(3);
    chk_model("R10 remote wakeup ignored under error");
    tick(IDLE + 16);
    chk_model("R9 error sticky over idle");
    chk_irq("R8 no repeat pulse while suspended", base + 1);
    erratic_i = 1'b1; soft_disc_i = 1'b1; tick(1);
    erratic_i = 1'b0; soft_disc_i = 1'b0; tick(3);
    chk_model("R10 erratic wins over soft disconnect");
    pulse(soft_disc_i); tick(3);
    m_er = 1'b0; m_su = 1'b0;
    chk_model("R10 soft disconnect clears error");

    // erratic while already idle-suspended
    toggle_lines(); tick(IDLE + 8);
    m_su = 1'b1;
    chk_model("R5 idle suspend before erratic");
    chk_irq("R8 pulse on idle entry", base + 2);
    pulse(erratic_i); tick(3);
    m_er = 1'b1;
    chk_model("R9 erratic while suspended");
    chk_irq("R8 no pulse when already suspended", base + 2);
    pulse(soft_disc_i); tick(3);
    m_er = 1'b0; m_su = 1'b0;
    chk_model("R10 soft disconnect after erratic");

    summary();
  end
endmodule